// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block detects one hazard in a five-stage in-order pipeline. An instruction that reads memory sits in the execute stage. The instruction right behind it, still in decode, reads the register that the load will write. The loaded value only returns at the end of the memory stage, so bypassing alone cannot deliver it in time. The interlock holds the front of the pipeline for one cycle and sends a no-op down in place of the consumer. On the next cycle the consumer is decoded again, and the load value can then reach it through the normal writeback bypass.

The unit is purely combinational and sits beside the decode stage. It reads the memory-read flag and the destination register number held in the decode/execute pipeline register. It compares that number with both source register numbers held in the fetch/decode pipeline register. When it stalls, it does three things at once:

- it withdraws the write enable of the program counter;
- it withdraws the write enable of the fetch/decode register;
- it steers the decoded control word entering the decode/execute register to all zeros.

An all-zero control word is a bubble: it writes no register and no memory, and it does not count as a load.

Top module: `lu_interlock`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, the block stalls: `pc_wr_en`=0, `ifid_wr_en`=0, `bubble_sel`=1.
- R2: When `ex_mem_read` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_b`, the block stalls in the same way.
- R3: When `ex_mem_read` is 0, no stall occurs, even if the register numbers match: both enables are 1 and `bubble_sel` is 0.
- R4: Register number 0 never causes a stall, whether or not a load is present.
- R5: A load whose destination matches neither source causes no stall.
- R6: During a stall, `idex_ctrl` is all zeros. Otherwise `idex_ctrl` equals `dec_ctrl`. Control bit 0 is the memory-read flag, bit 1 the memory-write flag and bit 2 the register-write flag.
- R7: In a pipeline built around the block, a load followed by a dependent instruction has the following effects:
  - the program counter holds for exactly one cycle;
  - the consumer stays in fetch/decode for two cycles;
  - exactly one zero-control bubble enters decode/execute;
  - the consumer's own control word follows the bubble.
- R8: A consumer whose two sources both match the load destination gets the same single stall as one matching source.
- R9: After reset, all pipeline control fields are zero. No stall is raised and the program counter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Memory-read flag of the instruction in execute |
| ex_dst | input | REG_AW | Destination register number of the instruction in execute |
| id_src_a | input | REG_AW | First source register number in decode |
| id_src_b | input | REG_AW | Second source register number in decode |
| dec_ctrl | input | CTRL_W | Control word produced by the decoder |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Selects all-zero control into decode/execute |
| idex_ctrl | output | CTRL_W | Control word to load into decode/execute |

## Verification
The comparison is tried under these input patterns:

- a load matching only the first source;
- a load matching only the second source;
- a load matching both sources;
- a load matching neither source;
- a non-load with matching numbers;
- a load whose destination is register zero.

Together these patterns separate the role of the load flag from the role of each comparator and of the zero filter. A small pipeline of program counter, fetch/decode and decode/execute registers then runs a short program. In that program, a true load-use pair shows the one-cycle freeze, the single bubble and the re-decode. A load to register zero followed by a reader of register zero shows that no false stall occurs.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned DEF_REG_AW = 5;
  localparam int unsigned DEF_CTRL_W = 8;
  localparam int unsigned NUM_SRC    = 2;
  localparam int unsigned CB_MEMRD   = 0;
  localparam int unsigned CB_MEMWR   = 1;
  localparam int unsigned CB_REGWR   = 2;

  // true when a producer writing 'dst' feeds a reader of 'src'
  function automatic logic reg_dep(input logic [31:0] dst, input logic [31:0] src);
    return (dst != 32'd0) && (dst == src);
  endfunction
endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
  parameter int unsigned REG_AW = lu_pkg::DEF_REG_AW
) (
  input  logic              is_load,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);
  localparam int unsigned PAD = 32 - REG_AW;
  logic dep;

  always_comb begin
    dep = lu_pkg::reg_dep({{PAD{1'b0}}, dst}, {{PAD{1'b0}}, src});
    hit = is_load & dep;
  end
endmodule

// File: rtl/lu_ctrl_zero.sv
module lu_ctrl_zero #(
  parameter int unsigned CTRL_W = lu_pkg::DEF_CTRL_W
) (
  input  logic              zero_sel,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);
  always_comb begin
    ctrl_out = zero_sel ? '0 : ctrl_in;
  end
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock #(
  parameter int unsigned REG_AW = lu_pkg::DEF_REG_AW,
  parameter int unsigned CTRL_W = lu_pkg::DEF_CTRL_W
) (
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              bubble_sel,
  output logic [CTRL_W-1:0] idex_ctrl
);
  localparam int unsigned NSRC = lu_pkg::NUM_SRC;

  logic [REG_AW-1:0] srcs [NSRC];
  logic [NSRC-1:0]   src_hit;
  logic              stall_evt;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    lu_src_cmp #(.REG_AW(REG_AW)) u_cmp (
      .is_load (ex_mem_read),
      .dst     (ex_dst),
      .src     (srcs[g]),
      .hit     (src_hit[g])
    );
  end

  assign stall_evt  = |src_hit;
  assign pc_wr_en   = ~stall_evt;
  assign ifid_wr_en = ~stall_evt;
  assign bubble_sel = stall_evt;

  lu_ctrl_zero #(.CTRL_W(CTRL_W)) u_zero (
    .zero_sel (bubble_sel),
    .ctrl_in  (dec_ctrl),
    .ctrl_out (idex_ctrl)
  );

  always_comb begin
    p_stall_src_a_r1: assert (!(ex_mem_read && ex_dst != '0 && ex_dst == id_src_a) || !pc_wr_en);
    p_stall_src_b_r2: assert (!(ex_mem_read && ex_dst != '0 && ex_dst == id_src_b) || !ifid_wr_en);
    p_no_load_no_stall_r3: assert (ex_mem_read || (pc_wr_en && ifid_wr_en && !bubble_sel));
    p_zero_reg_free_r4: assert (ex_dst != '0 || (pc_wr_en && !bubble_sel));
    p_bubble_zero_r6: assert (!bubble_sel || idex_ctrl == '0);
    p_pass_ctrl_r6: assert (bubble_sel || idex_ctrl == dec_ctrl);
    p_enables_agree_r7: assert (pc_wr_en == ifid_wr_en && pc_wr_en != bubble_sel);
  end
endmodule

// File: tb/test_lu_interlock.sv
module test_lu_interlock;
  localparam int CLK_P = 10;
  localparam int AW = 5;
  localparam int CW = 8;

  logic clk = 0, rst = 1;
  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;

  logic use_pipe = 0;
  logic d_ld; logic [AW-1:0] d_dst, d_a, d_b; logic [CW-1:0] d_ctrl;
  logic ex_mem_read; logic [AW-1:0] ex_dst, id_a, id_b; logic [CW-1:0] dec_ctrl;
  logic pc_wr_en, ifid_wr_en, bubble_sel; logic [CW-1:0] idex_ctrl;

  // bench pipeline state
  logic [7:0] pc;
  logic [CW-1:0] if_ctrl; logic [AW-1:0] if_dst, if_a, if_b;
  logic [CW-1:0] ex_ctrl; logic [AW-1:0] ex_d;

  function automatic logic [CW+3*AW-1:0] prog(input logic [7:0] p);
    case (p)
      8'd0: return {8'h05, 5'd5, 5'd1, 5'd0};  // load r5
      8'd1: return {8'h04, 5'd6, 5'd5, 5'd2};  // uses r5
      8'd2: return {8'h05, 5'd0, 5'd3, 5'd0};  // load to r0
      8'd3: return {8'h04, 5'd7, 5'd0, 5'd0};  // reads r0
      default: return {8'h04, 5'd8, 5'd9, 5'd10};
    endcase
  endfunction

  always_comb begin
    if (use_pipe) begin
      ex_mem_read = ex_ctrl[0]; ex_dst = ex_d; id_a = if_a; id_b = if_b; dec_ctrl = if_ctrl;
    end else begin
      ex_mem_read = d_ld; ex_dst = d_dst; id_a = d_a; id_b = d_b; dec_ctrl = d_ctrl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; if_ctrl <= '0; if_dst <= '0; if_a <= '0; if_b <= '0; ex_ctrl <= '0; ex_d <= '0;
    end else begin
      if (pc_wr_en) pc <= pc + 8'd1;
      if (ifid_wr_en) {if_ctrl, if_dst, if_a, if_b} <= prog(pc);
      ex_ctrl <= idex_ctrl;
      ex_d <= if_dst;
    end
  end

  lu_interlock #(.REG_AW(AW), .CTRL_W(CW)) i_lu_interlock (
    .ex_mem_read(ex_mem_read), .ex_dst(ex_dst), .id_src_a(id_a), .id_src_b(id_b),
    .dec_ctrl(dec_ctrl), .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
    .bubble_sel(bubble_sel), .idex_ctrl(idex_ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected stall outputs packed {pc_we, ifid_we, bubble, ctrl}
  task automatic drive_chk(input string req, input logic ld, input logic [AW-1:0] dst,
                           input logic [AW-1:0] a, input logic [AW-1:0] b, input logic stall);
    d_ld = ld; d_dst = dst; d_a = a; d_b = b; d_ctrl = 8'hA6;
    #1;
    chk(req, {pc_wr_en, ifid_wr_en, bubble_sel, idex_ctrl},
        stall ? {3'b001, 8'h00} : {3'b110, 8'hA6});
  endtask

  task automatic t_src_a;     drive_chk("R1", 1, 5'd9, 5'd9, 5'd3, 1); drive_chk("R1", 1, 5'd31, 5'd31, 5'd0, 1); endtask
  task automatic t_src_b;     drive_chk("R2", 1, 5'd4, 5'd1, 5'd4, 1); endtask
  task automatic t_not_load;  drive_chk("R3", 0, 5'd9, 5'd9, 5'd9, 0); endtask
  task automatic t_zero;      drive_chk("R4", 1, 5'd0, 5'd0, 5'd0, 0); drive_chk("R4", 0, 5'd0, 5'd0, 5'd0, 0); endtask
  task automatic t_nomatch;   drive_chk("R5", 1, 5'd12, 5'd13, 5'd11, 0); endtask
  task automatic t_both;      drive_chk("R8", 1, 5'd7, 5'd7, 5'd7, 1); endtask
  task automatic t_ctrl;      drive_chk("R6", 0, 5'd1, 5'd2, 5'd3, 0); drive_chk("R6", 1, 5'd2, 5'd2, 5'd3, 1); endtask

  task automatic t_pipeline;
    use_pipe = 1; rst = 1;
    @(posedge clk); @(negedge clk);
    chk("R9 ctrl", ex_ctrl, 0);
    chk("R9 pc_we", pc_wr_en, 1);
    rst = 0;
    @(posedge clk); @(negedge clk);               // load in IF/ID
    @(posedge clk); @(negedge clk);               // load in EX, consumer in ID
    chk("R7 stall", {pc_wr_en, bubble_sel}, 2'b01);
    chk("R7 pc", pc, 2);
    @(posedge clk); @(negedge clk);               // bubble in EX
    chk("R7 bubble", ex_ctrl, 0);
    chk("R7 pc held", pc, 2);
    chk("R7 redecode", if_a, 5);
    chk("R7 one cycle", pc_wr_en, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 consumer ctrl", ex_ctrl, 8'h04);
    chk("R7 pc moves", pc, 3);
    @(posedge clk); @(negedge clk);               // load r0 in EX, r0 reader in ID
    chk("R4 pipe", {ex_ctrl[0], pc_wr_en, bubble_sel}, 3'b110);
    use_pipe = 0;
  endtask

  initial begin
    #(CLK_P * 10000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    d_ld = 0; d_dst = 0; d_a = 0; d_b = 0; d_ctrl = 0;
    #2;
    t_src_a; t_src_b; t_not_load; t_zero; t_nomatch; t_both; t_ctrl;
    t_pipeline;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule